// File: doc/BRIEF.md
# Interleaved Text and Low-Resolution Video Address Generator

This block turns the scan position of a 40-column character display into the memory address the video scanner reads during the bus phase that belongs to video. Scan timing supplies a column count (0 to 64, of which 0 to 39 are visible) and a scan line count (0 to 191 visible, eight scan lines per text row and four per low-resolution block). The block maps each visible position into a 1 KB display page. The layout is interleaved: eight consecutive text rows are placed 128 bytes apart, and the three groups of eight rows are placed 40 bytes apart. Because of this layout, the low seven address bits used as the DRAM row address sweep the whole row space during normal scanning, and no separate refresh cycles are needed.

For visible columns the block issues a fetch strobe and the address. For the first eight blanking columns it issues a refresh-only strobe, so that the remaining DRAM rows are also visited. The byte that memory returns one cycle after a fetch is decoded two cycles after the fetch strobe. The text interpretation gives a rendering attribute and a 6-bit glyph code. The low-resolution interpretation gives the colour nibble for the current half of the character cell.

Top module: `vag_addr_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `fetch_o`, `rfsh_o` and `pix_valid_o` are 0.
- R2: If a clock edge samples `vid_phase_i`=1, `col_i`<40 and `line_i`<192, then in the next cycle `fetch_o`=1 and `addr_o` = base + 128*(r mod 8) + 40*(r div 8) + c, where r = `line_i` div 8 and c = `col_i`.
- R3: base is 0x0400 when `page2_i`=0 and 0x0800 when `page2_i`=1. Every fetched address lies inside the selected 1 KB page.
- R4: Text row 1, column 0 fetches 0x0480, and text row 8, column 0 fetches 0x0428. Two fetches for adjacent columns of the same scan line differ by exactly 1.
- R5: No fetch is issued in the cycle after an edge that sampled `vid_phase_i`=0, `col_i`>=40 (horizontal blanking) or `line_i`>=192.
- R6: If an edge samples `vid_phase_i`=1, `line_i`<192 and 40<=`col_i`<=47, then in the next cycle `rfsh_o`=1 and `fetch_o`=0, with the address computed by the R2 formula. `rfsh_o` and `fetch_o` are never 1 together.
- R7: While `fetch_o` or `rfsh_o` is 1, `dram_row_o` equals the low 7 bits of the address.
- R8: Two cycles after `fetch_o`=1, `pix_valid_o`=1 and the byte D read at that fetch (driven on `rd_data_i` in the cycle after the fetch) is decoded. `glyph_o` = D[5:0]. `attr_o` is 0 (normal) when D[7]=1, 1 (inverse) when D[7:6]=00, and 2 (flash) when D[7:6]=01. In every other cycle `pix_valid_o`=0.
- R9: With the same timing as R8, `color_o` is D[3:0] when bit 2 of the fetch's `line_i` is 0 (the upper block of the cell) and D[7:4] when that bit is 1.
- R10: One sweep of all 192 visible lines over columns 0 to 64 presents every DRAM row value 0 to 127 on `dram_row_o` under a fetch or refresh strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vid_phase_i | input | 1 | 1 when the bus phase belongs to video |
| col_i | input | 7 | Horizontal column count, 0 to 64 |
| line_i | input | 8 | Scan line count, 0 to 191 visible |
| page2_i | input | 1 | Selects the second display page |
| rd_data_i | input | 8 | Byte returned by memory in the cycle after a fetch |
| fetch_o | output | 1 | Video fetch strobe |
| rfsh_o | output | 1 | Refresh-only strobe during early blanking |
| addr_o | output | 16 | Fetch or refresh address |
| dram_row_o | output | 7 | DRAM row address for the current strobe |
| pix_valid_o | output | 1 | Decoded character outputs are valid |
| attr_o | output | 2 | Rendering attribute: 0 normal, 1 inverse, 2 flash |
| glyph_o | output | 6 | Glyph code |
| color_o | output | 4 | Low-resolution colour nibble |

## Verification
A wrong row-to-group split or a wrong stride shows on `addr_o` one cycle after the first column of the affected text row. Rows 1 and 8 are placed so that the two strides cannot be swapped without detection. A lost or misplaced refresh window leaves DRAM rows 120 to 127 unvisited, which becomes visible only at the end of a full sweep. A pipeline misalignment in decoding shows on `pix_valid_o`, `attr_o` or `color_o` two cycles after any fetch. A wrong nibble choice shows in the first scan line whose bit 2 differs.

// File: rtl/vag_pkg.sv
package vag_pkg;

  typedef enum logic [1:0] {
    ATTR_NORMAL  = 2'd0,
    ATTR_INVERSE = 2'd1,
    ATTR_FLASH   = 2'd2
  } attr_e;

  // Byte offset of a character cell inside a page with grouped rows.
  function automatic logic [15:0] cell_offset(
    input logic [15:0] row,
    input logic [15:0] col,
    input logic [15:0] group_rows,
    input logic [15:0] row_stride,
    input logic [15:0] cols
  );
    return (row % group_rows) * row_stride + (row / group_rows) * cols + col;
  endfunction

  function automatic attr_e classify_byte(input logic [7:0] b);
    if (b[7])      return ATTR_NORMAL;
    else if (b[6]) return ATTR_FLASH;
    else           return ATTR_INVERSE;
  endfunction

  function automatic logic [3:0] pick_nibble(input logic [7:0] b, input logic upper);
    return upper ? b[7:4] : b[3:0];
  endfunction

endpackage

// File: rtl/vag_window.sv
module vag_window #(
  parameter int COLS      = 40,
  parameter int RFSH_COLS = 8,
  parameter int VIS_LINES = 192,
  parameter int CW        = 7,
  parameter int LW        = 8
) (
  input  logic          vid_phase_i,
  input  logic [CW-1:0] col_i,
  input  logic [LW-1:0] line_i,
  output logic          fetch_win_o,
  output logic          rfsh_win_o
);
  localparam logic [CW-1:0] COL_END  = CW'(COLS);
  localparam logic [CW-1:0] RFSH_END = CW'(COLS + RFSH_COLS);
  localparam logic [LW-1:0] LINE_END = LW'(VIS_LINES);

  logic line_vis;
  logic col_vis;
  logic col_rfsh;

  always_comb begin
    line_vis    = line_i < LINE_END;
    col_vis     = col_i < COL_END;
    col_rfsh    = !col_vis && (col_i < RFSH_END);
    fetch_win_o = vid_phase_i && line_vis && col_vis;
    rfsh_win_o  = vid_phase_i && line_vis && col_rfsh;
  end
endmodule

// File: rtl/vag_addr.sv
module vag_addr
  import vag_pkg::*;
#(
  parameter int          CW            = 7,
  parameter int          LW            = 8,
  parameter int          AW            = 16,
  parameter int          COLS          = 40,
  parameter int          GROUP_ROWS    = 8,
  parameter int          ROW_STRIDE    = 128,
  parameter int          LPR_LOG2      = 3,
  parameter logic [15:0] PAGE1_BASE    = 16'h0400,
  parameter logic [15:0] PAGE2_BASE    = 16'h0800
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_win_i,
  input  logic          rfsh_win_i,
  input  logic [CW-1:0] col_i,
  input  logic [LW-1:0] line_i,
  input  logic          page2_i,
  output logic          fetch_o,
  output logic          rfsh_o,
  output logic [AW-1:0] addr_o,
  output logic          nib_upper_o
);
  logic [15:0] text_row;
  logic [15:0] base;
  logic [15:0] next_addr;

  always_comb begin
    text_row  = 16'(line_i >> LPR_LOG2);
    base      = page2_i ? PAGE2_BASE : PAGE1_BASE;
    next_addr = base + cell_offset(text_row, 16'(col_i), 16'(GROUP_ROWS),
                                   16'(ROW_STRIDE), 16'(COLS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_o     <= 1'b0;
      rfsh_o      <= 1'b0;
      addr_o      <= '0;
      nib_upper_o <= 1'b0;
    end else begin
      fetch_o <= fetch_win_i;
      rfsh_o  <= rfsh_win_i;
      if (fetch_win_i || rfsh_win_i) begin
        addr_o      <= AW'(next_addr);
        nib_upper_o <= line_i[LPR_LOG2-1];
      end
    end
  end
endmodule

// File: rtl/vag_decode.sv
module vag_decode
  import vag_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fetch_i,
  input  logic       nib_upper_i,
  input  logic [7:0] rd_data_i,
  output logic       pix_valid_o,
  output logic [1:0] attr_o,
  output logic [5:0] glyph_o,
  output logic [3:0] color_o
);
  logic data_due;
  logic nib_due;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_due    <= 1'b0;
      nib_due     <= 1'b0;
      pix_valid_o <= 1'b0;
      attr_o      <= 2'd0;
      glyph_o     <= '0;
      color_o     <= '0;
    end else begin
      data_due    <= fetch_i;
      nib_due     <= nib_upper_i;
      pix_valid_o <= data_due;
      if (data_due) begin
        attr_o  <= classify_byte(rd_data_i);
        glyph_o <= rd_data_i[5:0];
        color_o <= pick_nibble(rd_data_i, nib_due);
      end
    end
  end
endmodule

// File: rtl/vag_addr_gen.sv
module vag_addr_gen #(
  parameter int          COLS          = 40,
  parameter int          RFSH_COLS     = 8,
  parameter int          TEXT_ROWS     = 24,
  parameter int          LINES_PER_ROW = 8,
  parameter int          GROUP_ROWS    = 8,
  parameter int          PAGE_BYTES    = 1024,
  parameter int          DRAM_ROWS     = 128,
  parameter int          CW            = 7,
  parameter int          LW            = 8,
  parameter int          AW            = 16,
  parameter logic [15:0] PAGE1_BASE    = 16'h0400,
  parameter logic [15:0] PAGE2_BASE    = 16'h0800
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vid_phase_i,
  input  logic [CW-1:0] col_i,
  input  logic [LW-1:0] line_i,
  input  logic          page2_i,
  input  logic [7:0]    rd_data_i,
  output logic          fetch_o,
  output logic          rfsh_o,
  output logic [AW-1:0] addr_o,
  output logic [6:0]    dram_row_o,
  output logic          pix_valid_o,
  output logic [1:0]    attr_o,
  output logic [5:0]    glyph_o,
  output logic [3:0]    color_o
);
  localparam int VIS_LINES  = TEXT_ROWS * LINES_PER_ROW;
  localparam int ROW_STRIDE = PAGE_BYTES / GROUP_ROWS;
  localparam int LPR_LOG2   = $clog2(LINES_PER_ROW);
  localparam int RB         = $clog2(DRAM_ROWS);

  // Internal events named for the checker.
  logic fetch_win;
  logic rfsh_win;
  logic nib_upper;

  vag_window #(
    .COLS(COLS), .RFSH_COLS(RFSH_COLS), .VIS_LINES(VIS_LINES), .CW(CW), .LW(LW)
  ) u_window (
    .vid_phase_i (vid_phase_i),
    .col_i       (col_i),
    .line_i      (line_i),
    .fetch_win_o (fetch_win),
    .rfsh_win_o  (rfsh_win)
  );

  vag_addr #(
    .CW(CW), .LW(LW), .AW(AW), .COLS(COLS), .GROUP_ROWS(GROUP_ROWS),
    .ROW_STRIDE(ROW_STRIDE), .LPR_LOG2(LPR_LOG2),
    .PAGE1_BASE(PAGE1_BASE), .PAGE2_BASE(PAGE2_BASE)
  ) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_win_i (fetch_win),
    .rfsh_win_i  (rfsh_win),
    .col_i       (col_i),
    .line_i      (line_i),
    .page2_i     (page2_i),
    .fetch_o     (fetch_o),
    .rfsh_o      (rfsh_o),
    .addr_o      (addr_o),
    .nib_upper_o (nib_upper)
  );

  vag_decode u_decode (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_i     (fetch_o),
    .nib_upper_i (nib_upper),
    .rd_data_i   (rd_data_i),
    .pix_valid_o (pix_valid_o),
    .attr_o      (attr_o),
    .glyph_o     (glyph_o),
    .color_o     (color_o)
  );

  assign dram_row_o = 7'(addr_o[RB-1:0]);
endmodule

// File: rtl/vag_addr_gen_chk.sv
module vag_addr_gen_chk #(
  parameter int          COLS       = 40,
  parameter int          RFSH_COLS  = 8,
  parameter int          VIS_LINES  = 192,
  parameter int          PAGE_BYTES = 1024,
  parameter int          CW         = 7,
  parameter int          LW         = 8,
  parameter int          AW         = 16,
  parameter logic [15:0] PAGE1_BASE = 16'h0400,
  parameter logic [15:0] PAGE2_BASE = 16'h0800
) (
  input logic          clk,
  input logic          rst_n,
  input logic          vid_phase_i,
  input logic [CW-1:0] col_i,
  input logic [LW-1:0] line_i,
  input logic          page2_i,
  input logic          fetch_o,
  input logic          rfsh_o,
  input logic [AW-1:0] addr_o,
  input logic          pix_valid_o
);
  p_fetch_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_o |-> ($past(vid_phase_i) && ($past(col_i) < CW'(COLS))
                 && ($past(line_i) < LW'(VIS_LINES))));

  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_o && rfsh_o));

  p_rfsh_cols_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_o |-> ($past(col_i) >= CW'(COLS)) && ($past(col_i) < CW'(COLS + RFSH_COLS)));

  p_page_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_o |-> (32'(addr_o) >= 32'($past(page2_i) ? PAGE2_BASE : PAGE1_BASE))
             && (32'(addr_o) < 32'($past(page2_i) ? PAGE2_BASE : PAGE1_BASE) + PAGE_BYTES));

  p_col_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_o && $past(fetch_o) && ($past(line_i) == $past(line_i, 2))
     && ($past(page2_i) == $past(page2_i, 2))
     && ($past(col_i) == $past(col_i, 2) + CW'(1)))
    |-> (addr_o == $past(addr_o) + AW'(1)));

  p_pix_after_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid_o |-> $past(fetch_o, 2));
endmodule

bind vag_addr_gen vag_addr_gen_chk #(
  .COLS(COLS), .RFSH_COLS(RFSH_COLS), .VIS_LINES(VIS_LINES), .PAGE_BYTES(PAGE_BYTES),
  .CW(CW), .LW(LW), .AW(AW), .PAGE1_BASE(PAGE1_BASE), .PAGE2_BASE(PAGE2_BASE)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .vid_phase_i (vid_phase_i),
  .col_i       (col_i),
  .line_i      (line_i),
  .page2_i     (page2_i),
  .fetch_o     (fetch_o),
  .rfsh_o      (rfsh_o),
  .addr_o      (addr_o),
  .pix_valid_o (pix_valid_o)
);

// File: tb/tb_vag_addr_gen.sv
module tb_vag_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vid_phase_i = 1'b0;
  logic [6:0]  col_i = '0;
  logic [7:0]  line_i = '0;
  logic        page2_i = 1'b0;
  logic [7:0]  rd_data_i = '0;
  logic        fetch_o, rfsh_o, pix_valid_o;
  logic [15:0] addr_o;
  logic [6:0]  dram_row_o;
  logic [1:0]  attr_o;
  logic [5:0]  glyph_o;
  logic [3:0]  color_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [127:0] seen = '0;

  typedef struct {
    bit          fetch;
    bit          rfsh;
    logic [15:0] addr;
    bit          pix;
    logic [1:0]  attr;
    logic [5:0]  glyph;
    logic [3:0]  color;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t dly1, dly2;

  always #4 clk = ~clk;

  vag_addr_gen dut (.*);

  function automatic logic [7:0] memval(input logic [15:0] a);
    return a[7:0] ^ {a[10:8], a[4:0]} ^ 8'h5A;
  endfunction

  // Memory model: byte valid in the cycle after the fetch.
  always @(posedge clk) if (fetch_o) rd_data_i <= memval(addr_o);

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic step(input bit ph, input int col, input int line, input bit pg,
                      input string tag);
    exp_t e;
    int row;
    logic [7:0] b;
    @(negedge clk);
    vid_phase_i = ph;
    col_i       = 7'(col);
    line_i      = 8'(line);
    page2_i     = pg;
    row         = line / 8;
    e.fetch = ph && col < 40 && line < 192;
    e.rfsh  = ph && col >= 40 && col < 48 && line < 192;
    e.addr  = 16'((pg ? 'h800 : 'h400) + 128 * (row % 8) + 40 * (row / 8) + col);
    e.pix   = e.fetch;
    b       = memval(e.addr);
    e.glyph = b[5:0];
    e.attr  = b[7] ? 2'd0 : (b[6] ? 2'd2 : 2'd1);
    e.color = ((line / 4) % 2 == 1) ? b[7:4] : b[3:0];
    e.tag   = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: one expected item per driven cycle, pixel compared two cycles later.
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      chk(fetch_o == e.fetch, e.tag, "fetch_o", 32'(fetch_o), 32'(e.fetch));
      chk(rfsh_o == e.rfsh, e.rfsh ? "R6" : e.tag, "rfsh_o", 32'(rfsh_o), 32'(e.rfsh));
      if (e.fetch || e.rfsh) begin
        chk(addr_o == e.addr, e.tag, "addr_o", 32'(addr_o), 32'(e.addr));
        chk(dram_row_o == e.addr[6:0], "R7", "dram_row_o", 32'(dram_row_o), 32'(e.addr[6:0]));
      end
      if (fetch_o || rfsh_o) seen[dram_row_o] = 1'b1;
      chk(pix_valid_o == dly2.pix, "R8", "pix_valid_o", 32'(pix_valid_o), 32'(dly2.pix));
      if (dly2.pix) begin
        chk(attr_o == dly2.attr, "R8", "attr_o", 32'(attr_o), 32'(dly2.attr));
        chk(glyph_o == dly2.glyph, "R8", "glyph_o", 32'(glyph_o), 32'(dly2.glyph));
        chk(color_o == dly2.color, "R9", "color_o", 32'(color_o), 32'(dly2.color));
      end
      dly2 = dly1;
      dly1 = e;
    end
  end

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    dly1 = '{default: 0, tag: ""};
    dly2 = '{default: 0, tag: ""};
    repeat (3) @(posedge clk);
    #1;
    chk(!fetch_o && !rfsh_o && !pix_valid_o, "R1", "strobes in reset",
        32'({fetch_o, rfsh_o, pix_valid_o}), 32'(0));
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(!fetch_o && !rfsh_o && !pix_valid_o, "R1", "strobes after reset",
        32'({fetch_o, rfsh_o, pix_valid_o}), 32'(0));

    // Directed corners
    step(1, 0, 0, 0, "R2");
    step(1, 39, 0, 0, "R2");
    step(1, 0, 8, 0, "R4");      // row 1 -> 0x480
    step(1, 0, 64, 0, "R4");     // row 8 -> 0x428
    step(1, 5, 191, 0, "R2");
    step(1, 0, 0, 1, "R3");      // page 2 -> 0x800
    step(1, 39, 191, 1, "R3");
    step(0, 3, 4, 0, "R5");
    step(1, 40, 4, 0, "R6");
    step(1, 47, 130, 0, "R6");
    step(1, 48, 4, 0, "R5");
    step(1, 64, 4, 0, "R5");
    step(1, 10, 192, 0, "R5");
    step(1, 44, 200, 0, "R5");
    step(1, 7, 12, 0, "R9");     // lower block of cell
    step(1, 7, 3, 0, "R9");      // upper block of cell
    step(0, 0, 0, 0, "R5");
    step(0, 0, 0, 0, "R5");

    // Full sweep, alternating bus phases
    seen = '0;
    for (int ln = 0; ln < 192; ln++)
      for (int c = 0; c < 65; c++) begin
        step(0, c, ln, 0, "R5");
        step(1, c, ln, 0, "R2");
      end
    for (int k = 0; k < 3; k++) step(0, 0, 0, 0, "R5");
    @(posedge clk); #2;
    chk(&seen, "R10", "all DRAM rows visited", 32'($countones(seen)), 32'(128));

    // Partial sweep on page 2, every phase owned by video
    for (int ln = 0; ln < 24; ln++)
      for (int c = 0; c < 65; c++) step(1, c, ln, 1, "R3");
    for (int k = 0; k < 4; k++) step(0, 0, 0, 0, "R5");
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog expired actual=running expected=finished");
      report();
    end
  end
endmodule